// File: doc/BRIEF.md
# Section Overhead Regeneration Controller

This block sits on the transmit side of a SONET section/line terminator. Once per frame it decides which section overhead bytes the transmitter rebuilds locally and whether line AIS is forced downstream. The group of framing and parity bytes (A1/A2/B1) is handled separately from the optional bytes (J0, E1, F1 and the data communication channel). Each optional byte has its own provisioning bit that names the local generator as its source.

The decision depends on four things: the terminator mode, a fail state (loss of signal or loss of frame), two AIS enables (automatic and manual) and the per-byte provisioning. A pass-through AIS indication is also accepted. All results are captured on a frame-start pulse, so the byte inserter sees constant enables for the whole frame.

Top module: `soh_regen_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: The outputs change only at a rising edge where `frame_start` is 1. At any other edge they hold, whatever the other inputs do.
- R3: The fail state is `los` OR `lof`. In section mode (`sect_mode`=1) with a fail and at least one AIS enable set, `ais_l_gen` and `regen_aab` are both 1 after the frame-start edge.
- R4: In section mode with a fail and at least one AIS enable set, each of `regen_j0`, `regen_e1`, `regen_f1` and `regen_dcc` equals its provisioning bit.
- R5: In section mode with a fail and both AIS enables at 0, every regenerate output and `ais_l_gen` is 0.
- R6: Outside the section-mode fail case, when `ais_man_en`=1: `regen_aab`=1, each optional byte follows its provisioning bit, and `ais_l_gen`=0.
- R7: Outside the section-mode fail case, when `ais_man_en`=0: every regenerate output, including `regen_aab`, equals its own provisioning bit. `pass_ais` and `ais_auto_en` have no effect here.
- R8: `ais_l_gen` is 1 only after a frame-start edge at which section mode, a fail and at least one AIS enable were all present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| sect_mode | input | 1 | 1 = section terminator, 0 = line terminator |
| los | input | 1 | Loss of signal |
| lof | input | 1 | Loss of frame |
| ais_auto_en | input | 1 | Automatic AIS enable |
| ais_man_en | input | 1 | Manual AIS enable |
| pass_ais | input | 1 | Pass-through AIS indication |
| prov_aab | input | 1 | Local source provisioned for A1/A2/B1 |
| prov_j0 | input | 1 | Local source provisioned for J0 |
| prov_e1 | input | 1 | Local source provisioned for E1 |
| prov_f1 | input | 1 | Local source provisioned for F1 |
| prov_dcc | input | 1 | Local source provisioned for the DCC bytes |
| regen_aab | output | 1 | Regenerate A1/A2/B1 this frame |
| regen_j0 | output | 1 | Regenerate J0 this frame |
| regen_e1 | output | 1 | Regenerate E1 this frame |
| regen_f1 | output | 1 | Regenerate F1 this frame |
| regen_dcc | output | 1 | Regenerate DCC bytes this frame |
| ais_l_gen | output | 1 | Force line AIS this frame |

## Verification
The bench runs every combination of mode, both fail sources, both enables, pass-through AIS and the five provisioning bits. This catches several faults. A design that treats only one of `los` and `lof` as a fail misses AIS-L. One that lets `pass_ais` or the automatic enable act in line mode regenerates A1/A2/B1 without provisioning. One that forces A1/A2/B1 in a section fail with both enables off sends framing that should be absent. The bench also changes the inputs between frame-start pulses, so a design that is transparent instead of frame-latched shows moving enables. A reset in the middle of the run must clear outputs that were set.

// File: rtl/soh_regen_ctrl.sv
module soh_regen_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic sect_mode,
  input  logic los,
  input  logic lof,
  input  logic ais_auto_en,
  input  logic ais_man_en,
  input  logic pass_ais,
  input  logic prov_aab,
  input  logic prov_j0,
  input  logic prov_e1,
  input  logic prov_f1,
  input  logic prov_dcc,
  output logic regen_aab,
  output logic regen_j0,
  output logic regen_e1,
  output logic regen_f1,
  output logic regen_dcc,
  output logic ais_l_gen
);

  logic       fail, any_en, sect_fail;
  logic [3:0] opt_prov, opt_nxt;
  logic       aab_nxt, ais_nxt;

  assign fail      = los | lof;
  assign any_en    = ais_auto_en | ais_man_en;
  assign sect_fail = sect_mode & fail;
  assign opt_prov  = {prov_j0, prov_e1, prov_f1, prov_dcc};

  // pass_ais selects the same per-byte rule as the fallback, so it has no effect
  always_comb begin
    if (sect_fail) begin
      ais_nxt = any_en;
      aab_nxt = any_en;
      opt_nxt = any_en ? opt_prov : 4'b0;
    end else begin
      ais_nxt = 1'b0;
      aab_nxt = ais_man_en | prov_aab;
      opt_nxt = opt_prov;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {ais_l_gen, regen_aab, regen_j0, regen_e1, regen_f1, regen_dcc} <= '0;
    end else if (frame_start) begin
      ais_l_gen <= ais_nxt;
      regen_aab <= aab_nxt;
      {regen_j0, regen_e1, regen_f1, regen_dcc} <= opt_nxt;
    end
  end

  wire unused_ok = pass_ais;

endmodule

// File: rtl/soh_regen_ctrl_chk.sv
module soh_regen_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic sect_mode,
  input logic los,
  input logic lof,
  input logic ais_auto_en,
  input logic ais_man_en,
  input logic prov_aab,
  input logic regen_aab,
  input logic regen_j0,
  input logic regen_e1,
  input logic regen_f1,
  input logic regen_dcc,
  input logic ais_l_gen
);

  logic [5:0] outs;
  assign outs = {ais_l_gen, regen_aab, regen_j0, regen_e1, regen_f1, regen_dcc};

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> outs == 6'b0);

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(outs));

  // R3
  sect_fail_ais_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && sect_mode && (los || lof) && (ais_auto_en || ais_man_en)
    |=> ais_l_gen && regen_aab);

  // R5
  sect_fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && sect_mode && (los || lof) && !ais_auto_en && !ais_man_en
    |=> outs == 6'b0);

  // R6
  man_force_aab_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && !(sect_mode && (los || lof)) && ais_man_en
    |=> regen_aab && !ais_l_gen);

  // R7
  prov_follow_aab_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && !(sect_mode && (los || lof)) && !ais_man_en
    |=> regen_aab == $past(prov_aab));

  // R8
  ais_only_sect_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && !(sect_mode && (los || lof)) |=> !ais_l_gen);

endmodule

bind soh_regen_ctrl soh_regen_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .sect_mode(sect_mode),
  .los(los), .lof(lof), .ais_auto_en(ais_auto_en), .ais_man_en(ais_man_en),
  .prov_aab(prov_aab), .regen_aab(regen_aab), .regen_j0(regen_j0),
  .regen_e1(regen_e1), .regen_f1(regen_f1), .regen_dcc(regen_dcc),
  .ais_l_gen(ais_l_gen)
);

// File: tb/tb_soh_regen_ctrl.sv
module tb_soh_regen_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [10:0] stim = '0;
  logic regen_aab, regen_j0, regen_e1, regen_f1, regen_dcc, ais_l_gen;
  logic [5:0] outs;

  int n_tests = 0;
  int n_fail  = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  logic [5:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // stim: 10 mode, 9 los, 8 lof, 7 auto, 6 man, 5 pass, 4..0 prov aab/j0/e1/f1/dcc
  soh_regen_ctrl dut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .sect_mode(stim[10]), .los(stim[9]), .lof(stim[8]),
    .ais_auto_en(stim[7]), .ais_man_en(stim[6]), .pass_ais(stim[5]),
    .prov_aab(stim[4]), .prov_j0(stim[3]), .prov_e1(stim[2]),
    .prov_f1(stim[1]), .prov_dcc(stim[0]),
    .regen_aab(regen_aab), .regen_j0(regen_j0), .regen_e1(regen_e1),
    .regen_f1(regen_f1), .regen_dcc(regen_dcc), .ais_l_gen(ais_l_gen)
  );
  assign outs = {ais_l_gen, regen_aab, regen_j0, regen_e1, regen_f1, regen_dcc};

  function automatic logic [5:0] model(input logic [10:0] s);
    logic sf, en;
    sf = s[10] & (s[9] | s[8]);
    en = s[7] | s[6];
    if (sf && en)  return {2'b11, s[3:0]};
    if (sf)        return 6'b0;
    if (s[6])      return {2'b01, s[3:0]};
    return {1'b0, s[4:0]};
  endfunction

  function automatic string req_of(input logic [10:0] s);
    logic sf, en;
    sf = s[10] & (s[9] | s[8]);
    en = s[7] | s[6];
    if (sf && en) return "R3/R4/R8";
    if (sf)       return "R5";
    if (s[6])     return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [10:0] s);
    @(negedge clk);
    stim = s;
    frame_start = 1'b1;
    exp_q.push_back(model(s));
    tag_q.push_back(req_of(s));
    last_exp = model(s);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (frame_start && !rst) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), outs, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: outputs %b expected completion", outs);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    stim = 11'h7FF;
    frame_start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", outs, 6'b0);            // reset state, even with frame_start held
    rst = 1'b0;
    frame_start = 1'b0;
    @(negedge clk);

    // directed corners
    send_frame(11'b1_10_10_0_11111);   // R3: LOS only, auto enable
    send_frame(11'b1_01_01_0_10101);   // R3/R4: LOF only, manual enable
    send_frame(11'b1_11_00_1_11111);   // R5: section fail, no enable
    send_frame(11'b0_11_00_1_00000);   // R7: line fail, pass_ais, nothing provisioned
    send_frame(11'b0_11_11_1_01010);   // R6: line fail, manual forces aab
    send_frame(11'b1_00_10_0_00000);   // R7: no fail, auto has no effect

    // R2: inputs move without frame_start; outputs hold
    send_frame(11'b1_10_11_0_11111);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      stim = 11'b0_00_00_0_00000 ^ k[10:0];
      @(negedge clk);
      check("R2", outs, last_exp);
    end

    // exhaustive sweep
    for (int v = 0; v < 2048; v++) send_frame(v[10:0]);
    @(negedge clk);

    // R1: mid-run reset clears set outputs
    send_frame(11'b1_10_11_0_11111);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", outs, 6'b0);
    rst = 1'b0;
    send_frame(11'b1_01_10_0_01111);   // R8 after reset
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule